// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the strobe sequence for programmed-I/O transfers on one ATA channel that carries two devices. It runs from a 33 MHz timing clock, so one clock is about 30 ns. Each transfer has three phases. First the address is valid with no strobe (setup). Then the read or the write strobe is asserted (active). Then the strobe is released while the address stays valid (recovery). A one-clock done pulse marks the final recovery clock.

Each device owns a timing byte. Its upper nibble encodes the active width and its lower nibble encodes the recovery time. Both use packed, non-linear codes. A two-bit code in the top bits of a setup byte selects the setup length. On a primary-style channel each device has its own setup byte. On a secondary-style channel (`SHARED_SETUP=1`) both devices share one setup byte. A small register port loads and reads back these bytes. A setup write can either replace the whole byte or change only the two code bits.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, both timing bytes read 0x00, every setup byte reads 0xC0, and addr_valid, rd_stb, wr_stb and done are low.
- R2: Register address encoding: cfg_addr[1]=0 selects a timing byte and cfg_addr[1]=1 selects a setup byte. cfg_addr[0] selects the device. A write with cfg_we=1 to a timing byte stores all 8 bits of cfg_wdata. cfg_rdata always shows the byte selected by cfg_addr.
- R3: A setup write with cfg_field=1 replaces only bits 7:6 and keeps bits 5:0. A setup write with cfg_field=0 replaces the whole byte.
- R4: With SHARED_SETUP=1, setup addresses 2 and 3 map to one byte that both devices use. With SHARED_SETUP=0, each device has its own setup byte.
- R5: A request (req=1) is taken only when no transfer is in progress. While a transfer runs, req is ignored and the transfer is never cut short.
- R6: Setup lasts 2, 3, 4 or 5 clocks for setup codes 01, 10, 00 and 11 (bits 7:6 of the device's setup byte). During setup, addr_valid=1 and both strobes are low.
- R7: Active lasts N clocks for active code N in bits 7:4 of the timing byte, with code 0 meaning 16. rd_stb is high when req_wr=0 and wr_stb is high when req_wr=1. The two strobes are never high together.
- R8: Recovery follows active. For recovery code r in bits 3:0 it lasts 16 clocks when r=0, 1 clock when r=15, and r+1 clocks otherwise. addr_valid stays high, both strobes are low, and done is high only in the last recovery clock.
- R9: addr_valid rises in the clock after the edge that takes the request. It falls in the clock after done, so there is at least one idle clock between transfers.
- R10: The timing and setup values are captured at the edge that takes the request. A register write during a transfer affects only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_field | input | 1 | For setup writes: 1 = change bits 7:6 only |
| cfg_addr | input | 2 | {setup/timing select, device} |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Byte selected by cfg_addr |
| req | input | 1 | Transfer request |
| req_dev | input | 1 | Device addressed by the request |
| req_wr | input | 1 | 1 = write transfer, 0 = read |
| addr_valid | output | 1 | High for the whole transfer |
| rd_stb | output | 1 | Read strobe (active high) |
| wr_stb | output | 1 | Write strobe (active high) |
| done | output | 1 | Pulse in the last recovery clock |

## Verification
The properties assume that reset is applied before the first transfer and that the register inputs are driven to known levels on every clock. They also assume that req and req_dev do not change between clock edges. The bench drives every input shortly after the rising edge and holds it for the whole clock. It lets requests and register writes collide with running transfers on purpose. That way the rule that requests are ignored while busy and the rule that timings are captured at the start are both exercised inside the stated assumptions.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = 4;
  localparam int CODE_W   = 2;
  localparam int MAX_CLKS = 1 << NIB_W;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_t;
endpackage

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
  import ata_pio_pkg::*;
#(
  parameter int SHARED_SETUP = 0,
  parameter int NDEV         = 2,
  localparam int DEV_W       = $clog2(NDEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_field,
  input  logic [DEV_W:0]    cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic [DEV_W-1:0]  seq_dev,
  output logic [BYTE_W-1:0] seq_tim,
  output logic [CODE_W-1:0] seq_code
);
  localparam int NSET = (SHARED_SETUP != 0) ? 1 : NDEV;
  localparam logic [BYTE_W-1:0] TIM_RST = '0;
  localparam logic [BYTE_W-1:0] SET_RST = {{CODE_W{1'b1}}, {(BYTE_W-CODE_W){1'b0}}};

  logic [BYTE_W-1:0] tim_q [NDEV];
  logic [BYTE_W-1:0] set_q [NSET];
  logic [BYTE_W-1:0] cfg_set, seq_set;
  logic              sel_setup;
  logic [DEV_W-1:0]  sel_dev;

  assign sel_setup = cfg_addr[DEV_W];
  assign sel_dev   = cfg_addr[DEV_W-1:0];

  for (genvar d = 0; d < NDEV; d++) begin : g_tim
    always_ff @(posedge clk) begin
      if (rst) begin
        tim_q[d] <= TIM_RST;
      end else if (cfg_we && !sel_setup && sel_dev == DEV_W'(d)) begin
        tim_q[d] <= cfg_wdata;
      end
    end
  end

  for (genvar s = 0; s < NSET; s++) begin : g_set
    logic hit;
    assign hit = cfg_we && sel_setup && ((SHARED_SETUP != 0) || sel_dev == DEV_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        set_q[s] <= SET_RST;
      end else if (hit) begin
        if (cfg_field)
          set_q[s] <= {cfg_wdata[BYTE_W-1 -: CODE_W], set_q[s][BYTE_W-CODE_W-1:0]};
        else
          set_q[s] <= cfg_wdata;
      end
    end

    // R3: a code-only write leaves the low bits of the setup byte alone
    assert_field_keep_R3: assert property (@(posedge clk) disable iff (rst)
      (hit && cfg_field) |=>
        (set_q[s][BYTE_W-CODE_W-1:0] == $past(set_q[s][BYTE_W-CODE_W-1:0])));
  end

  if (SHARED_SETUP != 0) begin : g_rd_shared
    assign cfg_set = set_q[0];
    assign seq_set = set_q[0];
  end else begin : g_rd_split
    assign cfg_set = set_q[sel_dev];
    assign seq_set = set_q[seq_dev];
  end

  assign cfg_rdata = sel_setup ? cfg_set : tim_q[sel_dev];
  assign seq_tim   = tim_q[seq_dev];
  assign seq_code  = seq_set[BYTE_W-1 -: CODE_W];
endmodule

// File: rtl/ata_pio_decode.sv
module ata_pio_decode
  import ata_pio_pkg::*;
(
  input  logic [BYTE_W-1:0] tim_byte,
  input  logic [CODE_W-1:0] setup_code,
  output logic [CNT_W-1:0]  setup_clks,
  output logic [CNT_W-1:0]  act_clks,
  output logic [CNT_W-1:0]  rec_clks
);
  logic [NIB_W-1:0] act_code, rec_code;

  assign act_code = tim_byte[BYTE_W-1 -: NIB_W];
  assign rec_code = tim_byte[NIB_W-1:0];

  always_comb begin
    unique case (setup_code)
      2'b01:   setup_clks = CNT_W'(2);
      2'b10:   setup_clks = CNT_W'(3);
      2'b00:   setup_clks = CNT_W'(4);
      default: setup_clks = CNT_W'(5);
    endcase
  end

  always_comb begin
    if (act_code == '0) act_clks = CNT_W'(MAX_CLKS);
    else                act_clks = CNT_W'(act_code);
  end

  always_comb begin
    if (rec_code == '0)          rec_clks = CNT_W'(MAX_CLKS);
    else if (rec_code == '1)     rec_clks = CNT_W'(1);
    else                         rec_clks = CNT_W'(rec_code) + CNT_W'(1);
  end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] setup_clks,
  input  logic [CNT_W-1:0] act_clks,
  input  logic [CNT_W-1:0] rec_clks,
  output logic             addr_valid,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);
  phase_t           ph, ph_n;
  logic [CNT_W-1:0] cnt, cnt_n, act_q, rec_q;
  logic             wr_q, wr_n, take;

  assign take = (ph == PH_IDLE) && req;
  assign wr_n = take ? req_wr : wr_q;

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    unique case (ph)
      PH_IDLE: begin
        if (req) begin
          ph_n  = PH_SETUP;
          cnt_n = setup_clks - CNT_W'(1);
        end
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          ph_n  = PH_ACT;
          cnt_n = act_q - CNT_W'(1);
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      PH_ACT: begin
        if (cnt == '0) begin
          ph_n  = PH_REC;
          cnt_n = rec_q - CNT_W'(1);
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
      default: begin
        if (cnt == '0) begin
          ph_n  = PH_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt - CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      act_q      <= '0;
      rec_q      <= '0;
      wr_q       <= 1'b0;
      addr_valid <= 1'b0;
      rd_stb     <= 1'b0;
      wr_stb     <= 1'b0;
      done       <= 1'b0;
    end else begin
      ph  <= ph_n;
      cnt <= cnt_n;
      wr_q <= wr_n;
      if (take) begin
        act_q <= act_clks;
        rec_q <= rec_clks;
      end
      addr_valid <= (ph_n != PH_IDLE);
      rd_stb     <= (ph_n == PH_ACT) && !wr_n;
      wr_stb     <= (ph_n == PH_ACT) && wr_n;
      done       <= (ph_n == PH_REC) && (cnt_n == '0);
    end
  end

  logic [CNT_W:0] strobe_run;
  always_ff @(posedge clk) begin
    if (rst)                  strobe_run <= '0;
    else if (rd_stb || wr_stb) strobe_run <= strobe_run + 1'b1;
    else                      strobe_run <= '0;
  end

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_stb, wr_stb}));
  assert_strobe_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> addr_valid);
  assert_strobe_len_R7: assert property (@(posedge clk) disable iff (rst)
    strobe_run <= (CNT_W+1)'(MAX_CLKS));
  assert_setup_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_valid) |-> (!rd_stb && !wr_stb));
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (addr_valid && !rd_stb && !wr_stb));
  assert_done_gap_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !addr_valid);
  assert_no_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !done) |=> addr_valid);
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int SHARED_SETUP = 0,
  parameter int NDEV         = 2,
  localparam int DEV_W       = $clog2(NDEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_field,
  input  logic [DEV_W:0]    cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              req,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic              req_wr,
  output logic              addr_valid,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done
);
  logic [BYTE_W-1:0] seq_tim;
  logic [CODE_W-1:0] seq_code;
  logic [CNT_W-1:0]  setup_clks, act_clks, rec_clks;

  ata_pio_regs #(.SHARED_SETUP(SHARED_SETUP), .NDEV(NDEV)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .seq_dev(req_dev), .seq_tim(seq_tim), .seq_code(seq_code)
  );

  ata_pio_decode u_dec (
    .tim_byte(seq_tim), .setup_code(seq_code),
    .setup_clks(setup_clks), .act_clks(act_clks), .rec_clks(rec_clks)
  );

  ata_pio_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr),
    .setup_clks(setup_clks), .act_clks(act_clks), .rec_clks(rec_clks),
    .addr_valid(addr_valid), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
  );
endmodule

// File: tb/ata_pio_timer_bench.sv
`timescale 1ns/1ps
module ata_pio_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_field = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic req = 1'b0, req_dev = 1'b0, req_wr = 1'b0;

  logic [7:0] rdata [2];
  logic av [2], rds [2], wrs [2], dn [2];

  always #2 clk = ~clk;

  ata_pio_timer #(.SHARED_SETUP(0)) u_ata_pio_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata[0]),
    .req(req), .req_dev(req_dev), .req_wr(req_wr),
    .addr_valid(av[0]), .rd_stb(rds[0]), .wr_stb(wrs[0]), .done(dn[0]));

  ata_pio_timer #(.SHARED_SETUP(1)) u_ata_pio_timer_sec (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata[1]),
    .req(req), .req_dev(req_dev), .req_wr(req_wr),
    .addr_valid(av[1]), .rd_stb(rds[1]), .wr_stb(wrs[1]), .done(dn[1]));

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_en = 0, finished = 0;
  string tag = "R1";

  // reference model, one per instance (k=1 shares its setup byte)
  int m_ph [2], m_cnt [2], m_act [2], m_rec [2];
  bit m_wr [2];
  int m_tim [2][2], m_set [2][2];

  function automatic int setup_len(int code);
    if (code == 1) return 2;
    if (code == 2) return 3;
    if (code == 0) return 4;
    return 5;
  endfunction
  function automatic int act_len(int c);
    return (c == 0) ? 16 : c;
  endfunction
  function automatic int rec_len(int c);
    if (c == 0) return 16;
    if (c == 15) return 1;
    return c + 1;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_ph[k] = 0; m_cnt[k] = 0; m_wr[k] = 0;
        for (int d = 0; d < 2; d++) begin
          m_tim[k][d] = 8'h00; m_set[k][d] = 8'hC0;
        end
      end else begin
        if (m_ph[k] == 0) begin
          if (req) begin
            m_ph[k]  = 1;
            m_cnt[k] = setup_len((m_set[k][req_dev] >> 6) & 3);
            m_act[k] = act_len((m_tim[k][req_dev] >> 4) & 15);
            m_rec[k] = rec_len(m_tim[k][req_dev] & 15);
            m_wr[k]  = req_wr;
          end
        end else if (m_cnt[k] > 1) begin
          m_cnt[k] = m_cnt[k] - 1;
        end else if (m_ph[k] == 1) begin
          m_ph[k] = 2; m_cnt[k] = m_act[k];
        end else if (m_ph[k] == 2) begin
          m_ph[k] = 3; m_cnt[k] = m_rec[k];
        end else begin
          m_ph[k] = 0; m_cnt[k] = 0;
        end
        if (cfg_we) begin
          if (cfg_addr[1]) begin
            for (int d = 0; d < 2; d++) begin
              if (k == 1 || d == int'(cfg_addr[0])) begin
                if (cfg_field)
                  m_set[k][d] = (cfg_wdata & 8'hC0) | (m_set[k][cfg_addr[0]] & 8'h3F);
                else
                  m_set[k][d] = cfg_wdata;
              end
            end
          end else begin
            m_tim[k][cfg_addr[0]] = cfg_wdata;
          end
        end
      end
    end
  end

  task automatic chk(string rq, string what, int k, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s inst%0d t=%0t: actual=%0h expected=%0h",
               rq, tag, what, k, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      for (int k = 0; k < 2; k++) begin
        int exp_rd;
        chk("R9", "addr_valid", k, int'(av[k]), int'(m_ph[k] != 0));
        chk("R7", "rd_stb", k, int'(rds[k]), int'(m_ph[k] == 2 && !m_wr[k]));
        chk("R7", "wr_stb", k, int'(wrs[k]), int'(m_ph[k] == 2 && m_wr[k]));
        chk("R8", "done", k, int'(dn[k]), int'(m_ph[k] == 3 && m_cnt[k] == 1));
        exp_rd = cfg_addr[1] ? m_set[k][cfg_addr[0]] : m_tim[k][cfg_addr[0]];
        chk("R2", "cfg_rdata", k, int'(rdata[k]), exp_rd);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<100000", cycles);
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(int addr, bit field, int data);
    cfg_addr = 2'(addr); cfg_field = field; cfg_wdata = 8'(data); cfg_we = 1'b1;
    step();
    cfg_we = 1'b0; cfg_field = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_ph[0] != 0 || m_ph[1] != 0) step();
  endtask

  task automatic xfer(int dev, bit wr);
    wait_idle();
    req_dev = dev[0]; req_wr = wr; req = 1'b1;
    step();
    req = 1'b0;
    wait_idle();
    step();
  endtask

  initial begin
    // R1: reset state, read every register
    step(); step(); cmp_en = 1; step();
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin cfg_addr = 2'(a); step(); end

    // R2, R3, R4: loads and readback
    tag = "R2";
    wr_reg(0, 0, 8'h23);
    wr_reg(1, 1, 8'hF7);       // field flag has no effect on timing bytes
    tag = "R3";
    wr_reg(2, 1, 8'h7F);       // code 01, low bits keep 00
    wr_reg(3, 0, 8'h95);       // full write
    tag = "R4";
    for (int a = 0; a < 4; a++) begin cfg_addr = 2'(a); step(); end
    wr_reg(3, 1, 8'h00);       // code 00, low bits stay 0x15
    for (int a = 2; a < 4; a++) begin cfg_addr = 2'(a); step(); end

    // R6, R7, R8: read and write transfers on both devices
    tag = "R6";
    xfer(0, 0); xfer(1, 1); xfer(0, 1); xfer(1, 0);

    // sweep setup codes and edge encodings of active and recovery
    tag = "R8";
    for (int sc = 0; sc < 4; sc++) begin
      wr_reg(2, 1, sc << 6);
      wr_reg(3, 1, (3 - sc) << 6);
      foreach (m_act[i]) begin end
      for (int v = 0; v < 6; v++) begin
        int tb;
        case (v)
          0: tb = 8'h00; 1: tb = 8'h1F; 2: tb = 8'h11;
          3: tb = 8'hFE; 4: tb = 8'h80; default: tb = 8'h5A;
        endcase
        wr_reg(0, 0, tb);
        wr_reg(1, 0, (tb + 8'h37) & 8'hFF);
        xfer(v % 2, v[0] ^ sc[0]);
        xfer((v + 1) % 2, v[1]);
      end
    end

    // R5: request held high through several transfers and pulsed while busy
    tag = "R5";
    wr_reg(0, 0, 8'h32);
    wait_idle();
    req_dev = 1'b0; req_wr = 1'b0; req = 1'b1;
    for (int i = 0; i < 70; i++) begin
      req_wr = i[2];
      req_dev = i[3];
      step();
    end
    req = 1'b0;
    wait_idle(); step();

    // R10: register writes during a running transfer apply to the next one
    tag = "R10";
    wr_reg(0, 0, 8'h44);
    wr_reg(2, 0, 8'h40);
    wait_idle();
    req_dev = 1'b0; req_wr = 1'b1; req = 1'b1;
    step();
    req = 1'b0;
    wr_reg(0, 0, 8'h0F);
    wr_reg(2, 1, 8'hC0);
    wr_reg(3, 1, 8'h80);
    wait_idle(); step();
    xfer(0, 0);

    // R1: reset in the middle of a transfer
    tag = "R1";
    req_dev = 1'b1; req = 1'b1; step(); req = 1'b0;
    step(); step();
    rst = 1'b1; step(); step();
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin cfg_addr = 2'(a); step(); end
    xfer(1, 1);

    finish_run();
  end
endmodule